// File: doc/BRIEF.md
# Switch-Level Inverter Network Evaluator

This block evaluates tiny transistor-style inverter networks in a six-valued signal algebra. The algebra has strong 0 and 1, weak 0 and 1, a floating value and a conflict value. Three wirings are built in:

- **Complementary pair:** a pull-up switch and a pull-down switch.
- **Ratio stage:** a single pull-down switch fighting a weak pull-up.
- **Buffered:** the ratio stage followed by two more switches that restore a strong output.

A caller pulses `start` with an input code and a topology number. The block clears every internal node to floating and then performs one relaxation pass per clock cycle. Every node is recomputed from the previous node values with the connection rule. The block stops as soon as a pass leaves every node unchanged.

On completion the block holds the network output value, the number of passes taken and a verdict. The verdict is either settled or gave up. It gives up when a pass limit is reached with nodes still moving, and it then reports the conflict value. The pass counts show how deep each wiring is. The output values show the drive strength of each wiring: the ratio stage yields only a weak high, while the other two yield strong levels.

Top module: `switch_inverter_eval`

## Requirements
- R1: After reset, done, settled and no_conv are 0, iter_cnt is 0 and out_val is the floating code 4.
- R2: Value codes are 0 strong 0, 1 strong 1, 2 weak 0, 3 weak 1, 4 floating, 5 conflict; an input code of 6 or 7 is taken as conflict. Node resolution rules:
  - A floating contribution yields to any other value.
  - A conflict contribution dominates everything else.
  - A strong value overrides a weak one.
  - Two equal values give that value.
  - Opposite values of equal strength give conflict.
- R3: Topology 0 (complementary pair) outputs strong 1 for input 0 or 2, and strong 0 for input 1 or 3. It settles after 3 passes.
- R4: Topology 1 (ratio stage with weak pull-up) outputs weak 1 for input 0 or 2, and strong 0 for input 1 or 3. It settles after 3 passes.
- R5: Topologies 2 and 3 (buffered) output strong 1 for input 0 or 2, and strong 0 for input 1 or 3. They settle after 5 passes.
- R6: For input codes 4 to 7, every topology settles after 3 passes with output 5, because a switch whose control is floating or conflict drives conflict.
- R7: While idle, `start` captures the input code and topology and clears the nodes to floating. While running, `start` and any change of the inputs are ignored. From acceptance until completion, done is 0 and out_val is 4. After completion, the results hold until the next accepted start.
- R8: One pass runs per clock. done rises exactly iter_cnt clock edges after the edge that accepted start, and iter_cnt never exceeds MAX_ITER.
- R9: If MAX_ITER passes all change some node, the block stops with no_conv 1, settled 0, out_val 5 and iter_cnt equal to MAX_ITER.
- R10: When done is 1, exactly one of settled and no_conv is 1. Neither is 1 while done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation (accepted only while idle) |
| x_code | input | 3 | Input value code applied to the network |
| net_sel | input | 2 | Topology number |
| done | output | 1 | Evaluation finished, results valid |
| settled | output | 1 | Finished because a pass changed nothing |
| no_conv | output | 1 | Finished because the pass limit was reached |
| out_val | output | 3 | Output node value code |
| iter_cnt | output | CNT_W | Passes performed |

## Verification
The assertions take for granted the following about the inputs:
- `start`, `x_code` and `net_sel` are never unknown at a clock edge.
- Outside of a run, results change only because a start was accepted.

The stimulus respects this by driving every input on the falling edge and keeping `start` a pulse of one or two cycles. The sweep covers all eight input codes against all four topology numbers. Each case runs on a default instance and on a second instance with a three-pass limit, which forces the buffered network to give up. One case raises `start` with changed inputs in the middle of a run, to show that those inputs are ignored.

// File: rtl/swinv_pkg.sv
package swinv_pkg;

  typedef enum logic [2:0] {
    LV_S0 = 3'd0,
    LV_S1 = 3'd1,
    LV_W0 = 3'd2,
    LV_W1 = 3'd3,
    LV_Z  = 3'd4,
    LV_U  = 3'd5
  } lv_t;

  typedef enum logic [1:0] {
    NET_CMOS    = 2'd0,
    NET_RATIO   = 2'd1,
    NET_BUF     = 2'd2,
    NET_BUF_ALT = 2'd3
  } net_t;

  localparam int unsigned NODES = 6;
  // node slots: pull-up leg, pull-down leg, first stage, restore-high, restore-low, buffered out
  localparam int unsigned N_A = 0;
  localparam int unsigned N_B = 1;
  localparam int unsigned N_M = 2;
  localparam int unsigned N_C = 3;
  localparam int unsigned N_D = 4;
  localparam int unsigned N_O = 5;

  function automatic lv_t lv_norm(input logic [2:0] code);
    return (code <= 3'd5) ? lv_t'(code) : LV_U;
  endfunction

  function automatic logic lv_strong(input lv_t v);
    return (v == LV_S0) || (v == LV_S1);
  endfunction

  // two-input connection rule
  function automatic lv_t lv_join(input lv_t a, input lv_t b);
    if (a == LV_Z) return b;
    if (b == LV_Z) return a;
    if ((a == LV_U) || (b == LV_U)) return LV_U;
    if (a == b) return a;
    if (lv_strong(a) && !lv_strong(b)) return a;
    if (lv_strong(b) && !lv_strong(a)) return b;
    return LV_U;
  endfunction

  // pull device: weakens drive
  function automatic lv_t lv_weaken(input lv_t v);
    case (v)
      LV_S0, LV_W0: return LV_W0;
      LV_S1, LV_W1: return LV_W1;
      LV_Z:         return LV_Z;
      default:      return LV_U;
    endcase
  endfunction

  // amplifying switch, conducts on a 1-like control
  function automatic lv_t sw_n(input lv_t ctl, input lv_t src);
    case (ctl)
      LV_S1, LV_W1: return src;
      LV_S0, LV_W0: return LV_Z;
      default:      return LV_U;
    endcase
  endfunction

  // amplifying switch, conducts on a 0-like control
  function automatic lv_t sw_p(input lv_t ctl, input lv_t src);
    case (ctl)
      LV_S0, LV_W0: return src;
      LV_S1, LV_W1: return LV_Z;
      default:      return LV_U;
    endcase
  endfunction

endpackage

// File: rtl/inv_net_step.sv
module inv_net_step
  import swinv_pkg::*;
(
  input  net_t              net,
  input  lv_t               xin,
  input  lv_t [NODES-1:0]   cur,
  output lv_t [NODES-1:0]   nxt,
  output lv_t               tap
);

  always_comb begin
    for (int i = 0; i < NODES; i++) nxt[i] = LV_Z;
    case (net)
      NET_CMOS: begin
        nxt[N_A] = sw_p(xin, LV_S1);
        nxt[N_B] = sw_n(xin, LV_S0);
        nxt[N_M] = lv_join(cur[N_A], cur[N_B]);
      end
      NET_RATIO: begin
        nxt[N_A] = sw_n(xin, LV_S0);
        nxt[N_B] = lv_weaken(LV_S1);
        nxt[N_M] = lv_join(cur[N_A], cur[N_B]);
      end
      default: begin
        nxt[N_A] = sw_n(xin, LV_S0);
        nxt[N_B] = lv_weaken(LV_S1);
        nxt[N_M] = lv_join(cur[N_A], cur[N_B]);
        nxt[N_C] = sw_n(cur[N_M], LV_S1);
        nxt[N_D] = sw_n(xin, LV_S0);
        nxt[N_O] = lv_join(cur[N_C], cur[N_D]);
      end
    endcase
  end

  assign tap = (net == NET_BUF || net == NET_BUF_ALT) ? cur[N_O] : cur[N_M];

endmodule

// File: rtl/inv_net_ctrl.sv
module inv_net_ctrl #(
  parameter int unsigned MAX_ITER = 8,
  parameter int unsigned CNT_W    = $clog2(MAX_ITER + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             changed,
  output logic             load,
  output logic             running,
  output logic             ev_settle,
  output logic             ev_giveup,
  output logic             done,
  output logic             settled,
  output logic             no_conv,
  output logic [CNT_W-1:0] iter_cnt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_ITER - 1);

  assign load      = start && !running;
  assign ev_settle = running && !changed;
  assign ev_giveup = running && changed && (iter_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      done     <= 1'b0;
      settled  <= 1'b0;
      no_conv  <= 1'b0;
      iter_cnt <= '0;
    end else if (load) begin
      running  <= 1'b1;
      done     <= 1'b0;
      settled  <= 1'b0;
      no_conv  <= 1'b0;
      iter_cnt <= '0;
    end else if (running) begin
      iter_cnt <= iter_cnt + 1'b1;
      if (ev_settle) begin
        running <= 1'b0;
        done    <= 1'b1;
        settled <= 1'b1;
      end else if (ev_giveup) begin
        running <= 1'b0;
        done    <= 1'b1;
        no_conv <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/switch_inverter_eval.sv
module switch_inverter_eval
  import swinv_pkg::*;
#(
  parameter int unsigned MAX_ITER = 8,
  localparam int unsigned CNT_W   = $clog2(MAX_ITER + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       x_code,
  input  logic [1:0]       net_sel,
  output logic             done,
  output logic             settled,
  output logic             no_conv,
  output logic [2:0]       out_val,
  output logic [CNT_W-1:0] iter_cnt
);

  lv_t             x_q;
  net_t            net_q;
  lv_t [NODES-1:0] node_q;
  lv_t [NODES-1:0] node_d;
  lv_t             tap;
  lv_t             out_q;
  logic            changed;
  logic            load;
  logic            running;
  logic            ev_settle;
  logic            ev_giveup;

  inv_net_step u_step (
    .net (net_q),
    .xin (x_q),
    .cur (node_q),
    .nxt (node_d),
    .tap (tap)
  );

  assign changed = (node_d != node_q);

  inv_net_ctrl #(.MAX_ITER(MAX_ITER), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .changed   (changed),
    .load      (load),
    .running   (running),
    .ev_settle (ev_settle),
    .ev_giveup (ev_giveup),
    .done      (done),
    .settled   (settled),
    .no_conv   (no_conv),
    .iter_cnt  (iter_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= LV_Z;
      net_q <= NET_CMOS;
      out_q <= LV_Z;
      for (int i = 0; i < NODES; i++) node_q[i] <= LV_Z;
    end else if (load) begin
      x_q   <= lv_norm(x_code);
      net_q <= net_t'(net_sel);
      out_q <= LV_Z;
      for (int i = 0; i < NODES; i++) node_q[i] <= LV_Z;
    end else if (running) begin
      node_q <= node_d;
      if (ev_settle)      out_q <= tap;
      else if (ev_giveup) out_q <= LV_U;
    end
  end

  assign out_val = out_q;

endmodule

// File: rtl/inv_net_chk.sv
module inv_net_chk #(
  parameter int unsigned MAX_ITER = 8,
  parameter int unsigned CNT_W    = $clog2(MAX_ITER + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             running,
  input logic             ev_settle,
  input logic             ev_giveup,
  input logic             done,
  input logic             settled,
  input logic             no_conv,
  input logic [CNT_W-1:0] iter_cnt,
  input logic [2:0]       out_val,
  input logic [1:0]       net_q,
  input logic [2:0]       x_q
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(MAX_ITER);

  p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (settled != no_conv));

  p_verdict_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (settled || no_conv) |-> done);

  p_quiet_while_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (!done && out_val == 3'd4));

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(out_val) && $stable(iter_cnt)));

  p_settle_finishes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_settle |=> (done && settled && !running));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iter_cnt <= LIM);

  p_giveup_reports_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_giveup |=> (done && no_conv && out_val == 3'd5 && iter_cnt == LIM));

  p_ratio_weak_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && settled && net_q == 2'd1 && (x_q == 3'd0 || x_q == 3'd2)) |-> (out_val == 3'd3));

  p_buffer_strong_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && settled && net_q[1] && x_q <= 3'd3) |-> (out_val <= 3'd1));

  p_bad_input_conflict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && settled && x_q > 3'd3) |-> (out_val == 3'd5));

endmodule

bind switch_inverter_eval inv_net_chk #(.MAX_ITER(MAX_ITER), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .running   (running),
  .ev_settle (ev_settle),
  .ev_giveup (ev_giveup),
  .done      (done),
  .settled   (settled),
  .no_conv   (no_conv),
  .iter_cnt  (iter_cnt),
  .out_val   (out_val),
  .net_q     (net_q),
  .x_q       (x_q)
);

// File: tb/sim_switch_inverter_eval.sv
`timescale 1ns/1ps
module sim_switch_inverter_eval;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] x_code = 3'd0;
  logic [1:0] net_sel = 2'd0;

  logic       done0, set0, nc0;
  logic [2:0] out0;
  logic [3:0] cnt0;
  logic       done1, set1, nc1;
  logic [2:0] out1;
  logic [1:0] cnt1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  switch_inverter_eval u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .x_code(x_code), .net_sel(net_sel),
    .done(done0), .settled(set0), .no_conv(nc0), .out_val(out0), .iter_cnt(cnt0)
  );

  switch_inverter_eval #(.MAX_ITER(3)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .x_code(x_code), .net_sel(net_sel),
    .done(done1), .settled(set1), .no_conv(nc1), .out_val(out1), .iter_cnt(cnt1)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit is_low(input int x);
    return x == 0 || x == 2;
  endfunction

  function automatic bit is_high(input int x);
    return x == 1 || x == 3;
  endfunction

  // expected output code from the requirement tables
  function automatic int want_out(input int topo, input int x);
    if (!is_low(x) && !is_high(x)) return 5;   // R6
    if (is_high(x)) return 0;                  // R3 R4 R5
    return (topo == 1) ? 3 : 1;                // weak high only for the ratio stage
  endfunction

  function automatic int want_cnt(input int topo, input int x);
    return (topo >= 2 && (is_low(x) || is_high(x))) ? 5 : 3;
  endfunction

  function automatic string tag_of(input int topo, input int x);
    if (!is_low(x) && !is_high(x)) return "R6 R2";
    if (topo == 0) return "R3 R2";
    if (topo == 1) return "R4 R2";
    return "R5 R2";
  endfunction

  task automatic run_case(input int topo, input int x, input bit inject);
    int lat0 = 0;
    int lat1 = 0;
    int eo = want_out(topo, x);
    int ec = want_cnt(topo, x);
    string t = tag_of(topo, x);
    bit giveup1 = (topo >= 2) && (is_low(x) || is_high(x));
    @(negedge clk);
    net_sel = 2'(topo);
    x_code  = 3'(x);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 done low while running", int'(done0), 0);
    check("R7 out floating while running", int'(out0), 4);
    for (int i = 1; i <= 20; i++) begin
      if (inject && i == 1) begin
        start = 1'b1; net_sel = 2'(topo ^ 1); x_code = 3'(x ^ 1);
      end else if (inject && i == 2) begin
        start = 1'b0; net_sel = 2'(topo); x_code = 3'(x);
      end
      @(posedge clk);
      @(negedge clk);
      if (done0 && lat0 == 0) lat0 = i;
      if (done1 && lat1 == 0) lat1 = i;
      if (lat0 != 0 && lat1 != 0) break;
    end
    check({t, " output"}, int'(out0), eo);
    check({t, " pass count"}, int'(cnt0), ec);
    check("R8 done latency equals passes", lat0, ec);
    check("R10 settled", int'(set0), 1);
    check("R10 no_conv", int'(nc0), 0);
    if (inject) check("R7 start ignored while running", int'(out0), eo);
    if (giveup1) begin
      check("R9 limited no_conv", int'(nc1), 1);
      check("R9 limited settled", int'(set1), 0);
      check("R9 limited output", int'(out1), 5);
      check("R9 limited count", int'(cnt1), 3);
      check("R9 limited latency", lat1, 3);
    end else begin
      check("R9 limited instance settles", int'(set1), 1);
      check("R9 limited instance output", int'(out1), eo);
      check("R9 limited instance count", int'(cnt1), 3);
    end
    @(negedge clk);
    @(negedge clk);
    check("R7 result held", int'(out0), eo);
    check("R7 done held", int'(done0), 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 done", int'(done0), 0);
    check("R1 settled", int'(set0), 0);
    check("R1 no_conv", int'(nc0), 0);
    check("R1 count", int'(cnt0), 0);
    check("R1 out", int'(out0), 4);
    for (int topo = 0; topo < 4; topo++)
      for (int x = 0; x < 8; x++)
        run_case(topo, x, 1'b0);
    run_case(0, 0, 1'b1);
    run_case(2, 1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule